// File: doc/BRIEF.md
# Two-Digit BCD to Binary Converter (Modulo 40)

This block turns a two-digit decimal value held as BCD into its plain unsigned binary form. The tens digit is two bits wide, so it only reaches 0 to 3, and the units digit is four bits wide. Every input from 00 to 39 therefore maps to a binary result from 0 to 39, which fits in six bits.

The converter is purely combinational and is defined for all 64 digit combinations. An active-low enable gates it. While the enable is high, the result is forced to all ones and the error flag stays low. While the enable is low, a units code above nine counts as illegal. An illegal code raises the error flag and forces the result to all ones, so it can never be mistaken for a real value.

The block is meant to sit directly in a datapath wherever a small decimal field, such as a minutes or seconds digit pair, must be used as a binary number.

Top module: `bcd2bin_mod40`

## Requirements
- R1: With `en_n_i` = 0 and `units_i` in 0..9, `bin_o` equals 10 × `tens_i` + `units_i`.
- R2: With `en_n_i` = 0 and a legal units code, `bin_o` never exceeds 39.
- R3: With `en_n_i` = 1, `bin_o` is 6'b111111 whatever the digit inputs are.
- R4: With `en_n_i` = 1, `err_o` is 0 whatever the digit inputs are.
- R5: With `en_n_i` = 0 and `units_i` in 10..15, `err_o` is 1.
- R6: With `en_n_i` = 0 and `units_i` in 10..15, `bin_o` is 6'b111111.
- R7: With `en_n_i` = 0 and `units_i` in 0..9, `err_o` is 0, for every tens value 0..3.
- R8: The block holds no state. Both outputs reflect the present inputs within the same evaluation, with no clock involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tens_i | input | 2 | BCD tens digit, 0 to 3 |
| units_i | input | 4 | BCD units digit; codes 10 to 15 are illegal |
| en_n_i | input | 1 | Active-low enable; 1 forces the disabled code |
| bin_o | output | 6 | Binary result, or all ones when disabled or illegal |
| err_o | output | 1 | High when enabled and the units code is illegal |

## Verification
No register lies between any input and either output, so every result is due zero clock cycles after its stimulus. The bench applies each input set on a falling clock edge and samples both outputs one nanosecond later, well before the next rising edge. All 128 combinations of enable, tens and units are covered, and each sample is compared against 10 × T + U or against the disabled and illegal rules, computed arithmetically.

// File: rtl/bcd_conv_pkg.sv
package bcd_conv_pkg;

    localparam int TENS_W    = 2;
    localparam int UNITS_W   = 4;
    localparam int DIGIT_MAX = 9;
    localparam int RADIX     = DIGIT_MAX + 1;
    localparam int VAL_MAX   = RADIX * (2 ** TENS_W) - 1;
    localparam int BIN_W     = $clog2(VAL_MAX + 1);

    typedef enum logic [1:0] {
        MODE_OFF = 2'd0,
        MODE_BAD = 2'd1,
        MODE_OK  = 2'd2
    } conv_mode_t;

    typedef struct packed {
        logic [TENS_W-1:0]  tens;
        logic [UNITS_W-1:0] units;
    } digit_pair_t;

    typedef struct packed {
        logic [BIN_W-1:0] value;
        logic             flag;
    } conv_out_t;

    function automatic logic units_legal(input logic [UNITS_W-1:0] u);
        return u <= UNITS_W'(DIGIT_MAX);
    endfunction

endpackage

// File: rtl/bcd_units_check.sv
module bcd_units_check
    import bcd_conv_pkg::*;
(
    input  logic [UNITS_W-1:0] units_i,
    output logic               legal_o
);
    always_comb begin
        legal_o = units_legal(units_i);
    end
endmodule

// File: rtl/bcd_tens_scale.sv
module bcd_tens_scale
    import bcd_conv_pkg::*;
(
    input  logic [TENS_W-1:0] tens_i,
    output logic [BIN_W-1:0]  scaled_o
);
    logic [BIN_W-1:0] part [TENS_W];

    for (genvar g = 0; g < TENS_W; g++) begin : g_weight
        localparam logic [BIN_W-1:0] WEIGHT = BIN_W'(RADIX << g);
        assign part[g] = tens_i[g] ? WEIGHT : '0;
    end

    always_comb begin
        scaled_o = '0;
        for (int i = 0; i < TENS_W; i++) begin
            scaled_o = scaled_o + part[i];
        end
    end
endmodule

// File: rtl/bcd_out_select.sv
module bcd_out_select
    import bcd_conv_pkg::*;
(
    input  logic                en_n_i,
    input  logic                legal_i,
    input  logic [BIN_W-1:0]    scaled_i,
    input  logic [UNITS_W-1:0]  units_i,
    output conv_out_t           out_o
);
    conv_mode_t       mode;
    logic [BIN_W-1:0] sum;

    always_comb begin
        sum = scaled_i + BIN_W'(units_i);
    end

    always_comb begin
        if (en_n_i)        mode = MODE_OFF;
        else if (!legal_i) mode = MODE_BAD;
        else               mode = MODE_OK;
    end

    always_comb begin
        unique case (mode)
            MODE_OK:  out_o = '{value: sum, flag: 1'b0};
            MODE_BAD: out_o = '{value: '1,  flag: 1'b1};
            default:  out_o = '{value: '1,  flag: 1'b0};
        endcase
    end
endmodule

// File: rtl/bcd2bin_mod40.sv
module bcd2bin_mod40
    import bcd_conv_pkg::*;
(
    input  logic [1:0] tens_i,
    input  logic [3:0] units_i,
    input  logic       en_n_i,
    output logic [5:0] bin_o,
    output logic       err_o
);
    digit_pair_t      digits;
    logic             legal;
    logic [BIN_W-1:0] scaled;
    conv_out_t        result;

    assign digits = '{tens: tens_i, units: units_i};

    bcd_units_check u_check (
        .units_i (digits.units),
        .legal_o (legal)
    );

    bcd_tens_scale u_scale (
        .tens_i   (digits.tens),
        .scaled_o (scaled)
    );

    bcd_out_select u_sel (
        .en_n_i   (en_n_i),
        .legal_i  (legal),
        .scaled_i (scaled),
        .units_i  (digits.units),
        .out_o    (result)
    );

    assign bin_o = result.value;
    assign err_o = result.flag;
endmodule

// File: rtl/bcd2bin_mod40_chk.sv
module bcd2bin_mod40_chk (
    input logic [1:0] tens_i,
    input logic [3:0] units_i,
    input logic       en_n_i,
    input logic [5:0] bin_o,
    input logic       err_o
);
    always_comb begin
        if (en_n_i) begin
            assert_off_ones_R3: assert (bin_o == 6'b111111);
            assert_off_noerr_R4: assert (!err_o);
        end else if (units_i > 4'd9) begin
            assert_bad_flag_R5: assert (err_o);
            assert_bad_ones_R6: assert (bin_o == 6'b111111);
        end else begin
            assert_good_value_R1: assert (int'(bin_o) == 10 * int'(tens_i) + int'(units_i));
            assert_good_range_R2: assert (bin_o <= 6'd39);
            assert_good_noerr_R7: assert (!err_o);
        end
    end
endmodule

bind bcd2bin_mod40 bcd2bin_mod40_chk chk_i (
    .tens_i  (tens_i),
    .units_i (units_i),
    .en_n_i  (en_n_i),
    .bin_o   (bin_o),
    .err_o   (err_o)
);

// File: tb/bcd2bin_mod40_tb_top.sv
`timescale 1ns/1ps
module bcd2bin_mod40_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] tens;
    logic [3:0] units;
    logic       en_n;
    logic [5:0] bin;
    logic       err;

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    bcd2bin_mod40 dut_i (
        .tens_i  (tens),
        .units_i (units),
        .en_n_i  (en_n),
        .bin_o   (bin),
        .err_o   (err)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s: got %0d expected %0d (en_n=%0b T=%0d U=%0d)",
                     req, act, exp, en_n, tens, units);
        end
    endtask

    task automatic apply(input logic e, input int t, input int u);
        @(negedge clk);
        en_n  = e;
        tens  = 2'(t);
        units = 4'(u);
        #1;
    endtask

    initial begin
        en_n = 1'b1; tens = '0; units = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        #1;
        // Reset-time state: disabled drives all ones and no error (R3, R4)
        check("R3 idle", int'(bin), 63);
        check("R4 idle", int'(err), 0);

        for (int e = 1; e >= 0; e--) begin
            for (int t = 0; t < 4; t++) begin
                for (int u = 0; u < 16; u++) begin
                    apply(e[0], t, u);
                    if (e == 1) begin
                        check("R3", int'(bin), 63);
                        check("R4", int'(err), 0);
                    end else if (u > 9) begin
                        check("R5", int'(err), 1);
                        check("R6", int'(bin), 63);
                    end else begin
                        check("R1", int'(bin), 10 * t + u);
                        check("R2", int'(bin <= 6'd39), 1);
                        check("R7", int'(err), 0);
                    end
                end
            end
        end

        // R8: outputs follow inputs with no clock edge in between
        @(negedge clk);
        en_n = 1'b0; tens = 2'd3; units = 4'd9;
        #0.5;
        check("R8 a", int'(bin), 39);
        units = 4'd12;
        #0.5;
        check("R8 b", int'(err), 1);
        en_n = 1'b1;
        #0.5;
        check("R8 c", int'(err), 0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_errs++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule